// File: doc/BRIEF.md
# Four-Layer Two-Pipe Compositor

This block builds one output pixel from up to four rectangular layers. The layers are combined in two fixed stages. Each layer is assigned to one of two pipes. Inside a pipe there is no blending: the covering layer with the highest priority wins outright. The block then alpha-blends the winner of pipe 1 over the winner of pipe 0. When pipe 0 has nothing at that pixel, pipe 1 is blended over a background colour instead.

A display timing source presents the screen coordinate of the current pixel with a valid strobe. The fetch logic presents the ARGB value that each layer holds at that position. Placement, size, pipe, priority and global alpha are steady configuration inputs. An optional defect mode can be switched on. In that mode, an alpha-carrying layer at the bottom slot (pipe 0, priority 0) shows the background colour instead of its own pixels. The result comes out two clocks after the coordinate is accepted.

Top module: `dual_pipe_compositor`

## Requirements
- R1: While rst_n is low, out_valid is 0 and out_rgb is 0.
- R2: out_valid equals pix_valid as sampled two rising edges earlier. While out_valid is 0, out_rgb keeps its previous value.
- R3: A layer covers screen pixel (x, y) only when its enable bit is 1 and both X <= x < X+W and Y <= y < Y+H hold. X and Y are signed 16-bit two's complement. The screen coordinates, W and H are unsigned 16-bit. A layer with W = 0 or H = 0 covers nothing.
- R4: layer_pipe bit i = 0 places layer i in pipe 0, and 1 places it in pipe 1. A pipe outputs the RGB of its covering layer with the numerically largest priority, with no blending. On equal priority, the lower-numbered layer wins.
- R5: The per-pixel alpha is bits [31:24] of a layer's ARGB word, with red in [23:16], green in [15:8] and blue in [7:0]. When the layer's global-alpha enable is 1, its effective alpha is floor(A*G/255), where G is its 8-bit global alpha. Otherwise the effective alpha is A.
- R6: When both pipes have a winner, each output channel is floor((a*T + (255-a)*B)/255). Here a is the effective alpha of the pipe 1 winner, T is its channel and B is the pipe 0 winner's channel.
- R7: When pipe 0 has no winner, the pipe 1 winner is blended over bg_rgb by the R6 formula. When pipe 1 has no winner, the pipe 0 winner's RGB is output unchanged and its alpha has no effect.
- R8: When no layer covers the pixel, the output is bg_rgb. The background is black when bg_rgb is tied to zero.
- R9: With quirk_en = 1, a layer in pipe 0 with priority 0 whose effective alpha is below 255 contributes bg_rgb in place of its own RGB. It still takes part in selection by priority. With quirk_en = 0, or with an effective alpha of 255, the layer contributes its own RGB.
- R10: Layer i uses bits [16i+15:16i] of layer_x, layer_y, layer_w and layer_h, bits [2i+1:2i] of layer_prio, bits [8i+7:8i] of layer_galpha, bits [32i+31:32i] of layer_argb, and bit i of layer_en, layer_pipe and layer_galpha_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| layer_en | input | 4 | Per-layer enable |
| layer_pipe | input | 4 | Per-layer pipe select (0 or 1) |
| layer_prio | input | 8 | Per-layer 2-bit priority |
| layer_x | input | 64 | Per-layer signed 16-bit left edge |
| layer_y | input | 64 | Per-layer signed 16-bit top edge |
| layer_w | input | 64 | Per-layer unsigned 16-bit width |
| layer_h | input | 64 | Per-layer unsigned 16-bit height |
| layer_galpha | input | 32 | Per-layer 8-bit global alpha |
| layer_galpha_en | input | 4 | Per-layer global-alpha enable |
| layer_argb | input | 128 | Per-layer ARGB pixel at the current position |
| bg_rgb | input | 24 | Background colour |
| quirk_en | input | 1 | Bottom-slot alpha defect mode |
| pix_valid | input | 1 | Current coordinate is valid |
| pix_x | input | 16 | Screen x coordinate |
| pix_y | input | 16 | Screen y coordinate |
| out_valid | output | 1 | out_rgb carries a new pixel |
| out_rgb | output | 24 | Composited RGB pixel |

## Verification
The directed sweeps walk one row of pixels across layer edges that start at negative coordinates, and across zero-size layers, to tell off-by-one and sign-extension errors apart. Stacks of overlapping layers in a single pipe, including equal priorities, separate highest-priority selection and its tie-break from any blending. Pairs of layers across both pipes, with and without global alpha, with pipe 0 absent and with the defect mode on and off, separate the alpha product, the blend formula, the background fallback and the bottom-slot substitution. A long run of random configurations with gaps in the valid strobe is then compared on every clock against a behavioural model of the same rules.

// File: rtl/comp_pkg.sv
package comp_pkg;
    localparam int CH_W  = 8;
    localparam int RGB_W = 3 * CH_W;
    localparam int ARGB_W = 4 * CH_W;

    typedef struct packed {
        logic             hit;
        logic [CH_W-1:0]  alpha;
        logic [RGB_W-1:0] rgb;
    } pipe_pix_t;

    typedef struct packed {
        logic             s1_valid;
        pipe_pix_t        p0;
        pipe_pix_t        p1;
        logic [RGB_W-1:0] s1_bg;
        logic             out_valid;
        logic [RGB_W-1:0] out_rgb;
    } comp_state_t;
endpackage

// File: rtl/comp_layer_hit.sv
module comp_layer_hit
    import comp_pkg::*;
#(
    parameter int COORD_W = 16
) (
    input  logic                      en,
    input  logic signed [COORD_W-1:0] org_x,
    input  logic signed [COORD_W-1:0] org_y,
    input  logic [COORD_W-1:0]        ext_w,
    input  logic [COORD_W-1:0]        ext_h,
    input  logic [COORD_W-1:0]        scr_x,
    input  logic [COORD_W-1:0]        scr_y,
    input  logic [ARGB_W-1:0]         argb,
    input  logic [CH_W-1:0]           g_alpha,
    input  logic                      g_alpha_on,
    input  logic                      defect_slot,
    input  logic [RGB_W-1:0]          bg,
    output logic                      hit,
    output logic [CH_W-1:0]           alpha_eff,
    output logic [RGB_W-1:0]          rgb
);
    localparam int EXT_W = COORD_W + 2;
    localparam logic [2*CH_W-1:0] FULL_W = (2*CH_W)'((1 << CH_W) - 1);
    localparam logic [CH_W-1:0]   FULL   = CH_W'((1 << CH_W) - 1);

    logic signed [EXT_W-1:0] sx, sy, lo_x, lo_y, hi_x, hi_y;
    logic                    in_x, in_y;
    logic [2*CH_W-1:0]       prod;
    logic [CH_W-1:0]         pix_a;

    always_comb begin
        sx   = $signed({2'b00, scr_x});
        sy   = $signed({2'b00, scr_y});
        lo_x = $signed({{2{org_x[COORD_W-1]}}, org_x});
        lo_y = $signed({{2{org_y[COORD_W-1]}}, org_y});
        hi_x = lo_x + $signed({2'b00, ext_w});
        hi_y = lo_y + $signed({2'b00, ext_h});
        in_x = (sx >= lo_x) && (sx < hi_x);
        in_y = (sy >= lo_y) && (sy < hi_y);
        hit  = en && in_x && in_y;

        pix_a     = argb[ARGB_W-1 -: CH_W];
        prod      = (2*CH_W)'(pix_a) * (2*CH_W)'(g_alpha);
        alpha_eff = g_alpha_on ? CH_W'(prod / FULL_W) : pix_a;
        rgb       = (defect_slot && (alpha_eff != FULL)) ? bg : argb[RGB_W-1:0];
    end
endmodule

// File: rtl/comp_pipe_pick.sv
module comp_pipe_pick
    import comp_pkg::*;
#(
    parameter int   NUM_LAYERS = 4,
    parameter int   PRIO_W     = 2,
    parameter logic PIPE_ID    = 1'b0
) (
    input  logic [NUM_LAYERS-1:0]        hit,
    input  logic [NUM_LAYERS-1:0]        sel,
    input  logic [NUM_LAYERS*PRIO_W-1:0] prio,
    input  logic [NUM_LAYERS*CH_W-1:0]   alpha,
    input  logic [NUM_LAYERS*RGB_W-1:0]  rgb,
    output pipe_pix_t                    pick
);
    logic [PRIO_W-1:0] best;

    always_comb begin
        pick = '0;
        best = '0;
        for (int i = 0; i < NUM_LAYERS; i++) begin
            if (hit[i] && (sel[i] == PIPE_ID) &&
                (!pick.hit || (prio[i*PRIO_W +: PRIO_W] > best))) begin
                pick.hit   = 1'b1;
                pick.alpha = alpha[i*CH_W +: CH_W];
                pick.rgb   = rgb[i*RGB_W +: RGB_W];
                best       = prio[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/comp_blend.sv
module comp_blend
    import comp_pkg::*;
(
    input  pipe_pix_t        upper,
    input  pipe_pix_t        lower,
    input  logic [RGB_W-1:0] bg,
    output logic [RGB_W-1:0] rgb
);
    localparam int NUM_CH = RGB_W / CH_W;
    localparam logic [2*CH_W-1:0] DIV  = (2*CH_W)'((1 << CH_W) - 1);
    localparam logic [CH_W-1:0]   FULL = CH_W'((1 << CH_W) - 1);

    logic [RGB_W-1:0] base;
    logic [RGB_W-1:0] mixed;
    logic [CH_W-1:0]  a_top, a_bot;

    assign base  = lower.hit ? lower.rgb : bg;
    assign a_top = upper.alpha;
    assign a_bot = FULL - upper.alpha;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [2*CH_W-1:0] acc;
        always_comb begin
            acc = (2*CH_W)'(a_top) * (2*CH_W)'(upper.rgb[c*CH_W +: CH_W])
                + (2*CH_W)'(a_bot) * (2*CH_W)'(base[c*CH_W +: CH_W]);
            mixed[c*CH_W +: CH_W] = CH_W'(acc / DIV);
        end
    end

    assign rgb = upper.hit ? mixed : base;
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor
    import comp_pkg::*;
#(
    parameter int NUM_LAYERS = 4,
    parameter int PRIO_W     = 2,
    parameter int COORD_W    = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_LAYERS-1:0]         layer_en,
    input  logic [NUM_LAYERS-1:0]         layer_pipe,
    input  logic [NUM_LAYERS*PRIO_W-1:0]  layer_prio,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_x,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_y,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_w,
    input  logic [NUM_LAYERS*COORD_W-1:0] layer_h,
    input  logic [NUM_LAYERS*8-1:0]       layer_galpha,
    input  logic [NUM_LAYERS-1:0]         layer_galpha_en,
    input  logic [NUM_LAYERS*32-1:0]      layer_argb,
    input  logic [23:0]                   bg_rgb,
    input  logic                          quirk_en,
    input  logic                          pix_valid,
    input  logic [COORD_W-1:0]            pix_x,
    input  logic [COORD_W-1:0]            pix_y,
    output logic                          out_valid,
    output logic [23:0]                   out_rgb
);
    logic [NUM_LAYERS-1:0]       hit_v;
    logic [NUM_LAYERS*CH_W-1:0]  alpha_v;
    logic [NUM_LAYERS*RGB_W-1:0] rgb_v;
    pipe_pix_t                   pick0, pick1;
    logic [RGB_W-1:0]            blend_rgb;
    comp_state_t                 st_d, st_q;

    for (genvar i = 0; i < NUM_LAYERS; i++) begin : g_layer
        logic defect_slot;
        assign defect_slot = quirk_en && !layer_pipe[i] &&
                             (layer_prio[i*PRIO_W +: PRIO_W] == '0);
        comp_layer_hit #(.COORD_W(COORD_W)) u_hit (
            .en          (layer_en[i]),
            .org_x       (layer_x[i*COORD_W +: COORD_W]),
            .org_y       (layer_y[i*COORD_W +: COORD_W]),
            .ext_w       (layer_w[i*COORD_W +: COORD_W]),
            .ext_h       (layer_h[i*COORD_W +: COORD_W]),
            .scr_x       (pix_x),
            .scr_y       (pix_y),
            .argb        (layer_argb[i*ARGB_W +: ARGB_W]),
            .g_alpha     (layer_galpha[i*CH_W +: CH_W]),
            .g_alpha_on  (layer_galpha_en[i]),
            .defect_slot (defect_slot),
            .bg          (bg_rgb),
            .hit         (hit_v[i]),
            .alpha_eff   (alpha_v[i*CH_W +: CH_W]),
            .rgb         (rgb_v[i*RGB_W +: RGB_W])
        );
    end

    comp_pipe_pick #(.NUM_LAYERS(NUM_LAYERS), .PRIO_W(PRIO_W), .PIPE_ID(1'b0)) u_pick0 (
        .hit   (hit_v),
        .sel   (layer_pipe),
        .prio  (layer_prio),
        .alpha (alpha_v),
        .rgb   (rgb_v),
        .pick  (pick0)
    );

    comp_pipe_pick #(.NUM_LAYERS(NUM_LAYERS), .PRIO_W(PRIO_W), .PIPE_ID(1'b1)) u_pick1 (
        .hit   (hit_v),
        .sel   (layer_pipe),
        .prio  (layer_prio),
        .alpha (alpha_v),
        .rgb   (rgb_v),
        .pick  (pick1)
    );

    comp_blend u_blend (
        .upper (st_q.p1),
        .lower (st_q.p0),
        .bg    (st_q.s1_bg),
        .rgb   (blend_rgb)
    );

    always_comb begin
        st_d           = st_q;
        st_d.s1_valid  = pix_valid;
        if (pix_valid) begin
            st_d.p0    = pick0;
            st_d.p1    = pick1;
            st_d.s1_bg = bg_rgb;
        end
        st_d.out_valid = st_q.s1_valid;
        if (st_q.s1_valid) begin
            st_d.out_rgb = blend_rgb;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_valid;
    assign out_rgb   = st_q.out_rgb;
endmodule

// File: rtl/comp_checker.sv
module comp_checker #(
    parameter int NUM_LAYERS = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pix_valid,
    input logic [NUM_LAYERS-1:0] layer_en,
    input logic [23:0]           bg_rgb,
    input logic                  out_valid,
    input logic [23:0]           out_rgb
);
    logic [1:0] age_q;
    logic       rst_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= 2'd0;
        end else if (age_q != 2'd3) begin
            age_q <= age_q + 2'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_seen_q <= 1'b1;
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (!rst_n && rst_seen_q) |-> (!out_valid && (out_rgb == 24'd0)));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (out_valid == $past(pix_valid, 2)));

    // R2
    hold_rgb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q != 2'd0) && !out_valid) |-> $stable(out_rgb));

    // R8
    empty_bg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd3) && out_valid && ($past(layer_en, 2) == '0))
        |-> (out_rgb == $past(bg_rgb, 2)));
endmodule

bind dual_pipe_compositor comp_checker #(.NUM_LAYERS(NUM_LAYERS)) u_comp_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .layer_en  (layer_en),
    .bg_rgb    (bg_rgb),
    .out_valid (out_valid),
    .out_rgb   (out_rgb)
);

// File: tb/dual_pipe_compositor_bench.sv
module dual_pipe_compositor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NL = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [3:0]    layer_en, layer_pipe, layer_galpha_en;
    logic [7:0]    layer_prio;
    logic [63:0]   layer_x, layer_y, layer_w, layer_h;
    logic [31:0]   layer_galpha;
    logic [127:0]  layer_argb;
    logic [23:0]   bg_rgb;
    logic          quirk_en;
    logic          pix_valid;
    logic [15:0]   pix_x, pix_y;
    logic          out_valid;
    logic [23:0]   out_rgb;

    int          cfg_en[NL], cfg_pipe[NL], cfg_prio[NL];
    int          cfg_x[NL], cfg_y[NL], cfg_w[NL], cfg_h[NL];
    int          cfg_ga[NL], cfg_gen[NL];
    logic [31:0] cfg_argb[NL];
    logic [23:0] bg_val;
    bit          quirk_val;

    bit          exp_v[$];
    logic [23:0] exp_rgb[$];
    string       exp_tag[$];
    logic [23:0] last_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pipe_compositor u_dual_pipe_compositor (
        .clk(clk), .rst_n(rst_n), .layer_en(layer_en), .layer_pipe(layer_pipe),
        .layer_prio(layer_prio), .layer_x(layer_x), .layer_y(layer_y),
        .layer_w(layer_w), .layer_h(layer_h), .layer_galpha(layer_galpha),
        .layer_galpha_en(layer_galpha_en), .layer_argb(layer_argb),
        .bg_rgb(bg_rgb), .quirk_en(quirk_en), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y), .out_valid(out_valid), .out_rgb(out_rgb)
    );

    function automatic logic [23:0] ref_pixel(int px, int py);
        int win[2];
        int wp[2];
        int ae[NL];
        logic [23:0] col[NL];
        logic [23:0] base;
        logic [23:0] res;
        int a, p, ax;
        win[0] = -1; win[1] = -1; wp[0] = 0; wp[1] = 0;
        for (int l = 0; l < NL; l++) begin
            ax = int'(cfg_argb[l][31:24]);
            ae[l] = (cfg_gen[l] != 0) ? (ax * cfg_ga[l]) / 255 : ax;
            col[l] = cfg_argb[l][23:0];
            if (quirk_val && cfg_pipe[l] == 0 && cfg_prio[l] == 0 && ae[l] != 255)
                col[l] = bg_val;
            if (cfg_en[l] != 0 && px >= cfg_x[l] && px < cfg_x[l] + cfg_w[l] &&
                py >= cfg_y[l] && py < cfg_y[l] + cfg_h[l]) begin
                p = cfg_pipe[l];
                if (win[p] < 0 || cfg_prio[l] > wp[p]) begin
                    win[p] = l;
                    wp[p]  = cfg_prio[l];
                end
            end
        end
        base = (win[0] >= 0) ? col[win[0]] : bg_val;
        if (win[1] < 0) return base;
        a = ae[win[1]];
        for (int c = 0; c < 3; c++) begin
            res[c*8 +: 8] = 8'((a * int'(col[win[1]][c*8 +: 8]) +
                                (255 - a) * int'(base[c*8 +: 8])) / 255);
        end
        return res;
    endfunction

    task automatic set_layer(int l, int en, int pipe, int prio, int x, int y,
                             int w, int h, logic [31:0] argb, int ga, int gen);
        cfg_en[l] = en; cfg_pipe[l] = pipe; cfg_prio[l] = prio;
        cfg_x[l] = x; cfg_y[l] = y; cfg_w[l] = w; cfg_h[l] = h;
        cfg_argb[l] = argb; cfg_ga[l] = ga; cfg_gen[l] = gen;
    endtask

    task automatic clear_layers();
        for (int l = 0; l < NL; l++) set_layer(l, 0, 0, 0, 0, 0, 0, 0, 32'h0, 0, 0);
    endtask

    task automatic step(int px, int py, bit v, string tag);
        bit          ev;
        logic [23:0] er;
        string       et;
        @(negedge clk);
        ev = exp_v.pop_front();
        er = exp_rgb.pop_front();
        et = exp_tag.pop_front();
        checks++;
        if (out_valid !== ev || out_rgb !== er) begin
            errors++;
            $display("FAIL %s: valid/rgb actual %0b/%h expected %0b/%h",
                     et, out_valid, out_rgb, ev, er);
        end
        for (int l = 0; l < NL; l++) begin
            layer_en[l]            = (cfg_en[l] != 0);
            layer_pipe[l]          = (cfg_pipe[l] != 0);
            layer_galpha_en[l]     = (cfg_gen[l] != 0);
            layer_prio[l*2 +: 2]   = 2'(cfg_prio[l]);
            layer_x[l*16 +: 16]    = 16'(cfg_x[l]);
            layer_y[l*16 +: 16]    = 16'(cfg_y[l]);
            layer_w[l*16 +: 16]    = 16'(cfg_w[l]);
            layer_h[l*16 +: 16]    = 16'(cfg_h[l]);
            layer_galpha[l*8 +: 8] = 8'(cfg_ga[l]);
            layer_argb[l*32 +: 32] = cfg_argb[l];
        end
        bg_rgb    = bg_val;
        quirk_en  = quirk_val;
        pix_valid = v;
        pix_x     = 16'(px);
        pix_y     = 16'(py);
        if (v) last_rgb = ref_pixel(px, py);
        exp_v.push_back(v);
        exp_rgb.push_back(last_rgb);
        exp_tag.push_back(tag);
    endtask

    initial begin
        rst_n = 1'b0;
        layer_en = '0; layer_pipe = '0; layer_galpha_en = '0; layer_prio = '0;
        layer_x = '0; layer_y = '0; layer_w = '0; layer_h = '0;
        layer_galpha = '0; layer_argb = '0; bg_rgb = '0; quirk_en = 1'b0;
        pix_valid = 1'b0; pix_x = '0; pix_y = '0;
        bg_val = 24'h0; quirk_val = 1'b0; last_rgb = 24'h0;
        clear_layers();
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (out_valid !== 1'b0 || out_rgb !== 24'h0) begin
            errors++;
            $display("FAIL R1: valid/rgb actual %0b/%h expected 0/000000", out_valid, out_rgb);
        end
        rst_n = 1'b1;
        repeat (2) begin
            exp_v.push_back(1'b0); exp_rgb.push_back(24'h0); exp_tag.push_back("R1");
        end

        // R8: nothing enabled -> background; default black
        step(3, 3, 1'b1, "R8");
        bg_val = 24'h123456;
        step(0, 0, 1'b1, "R8");
        step(100, 7, 1'b1, "R8");

        // R3: signed origin, edges, zero-size layer
        set_layer(0, 1, 0, 0, -5, -3, 10, 8, 32'hFFAA5511, 0, 0);
        set_layer(1, 1, 1, 0, -5, -3, 0, 8, 32'hFF00FF00, 0, 0);
        for (int yy = 3; yy <= 5; yy++)
            for (int xx = 0; xx <= 6; xx++) step(xx, yy, 1'b1, "R3");

        // R4, R10: priority selection inside pipe 0, tie to lower index
        clear_layers();
        set_layer(0, 1, 0, 1, 0, 0, 8, 8, 32'hFF111111, 0, 0);
        set_layer(2, 1, 0, 3, 4, 0, 8, 8, 32'hFF222222, 0, 0);
        set_layer(3, 1, 0, 1, 0, 0, 20, 8, 32'h80333333, 0, 0);
        for (int xx = 0; xx <= 21; xx += 3) step(xx, 1, 1'b1, "R4 R10");

        // R5, R6: pipe 1 over pipe 0 with and without global alpha
        clear_layers();
        set_layer(0, 1, 0, 2, 0, 0, 16, 16, 32'hFF204060, 0, 0);
        set_layer(1, 1, 1, 0, 4, 4, 8, 8, 32'h80F0A010, 8'h40, 0);
        step(5, 5, 1'b1, "R6");
        step(1, 1, 1'b1, "R6");
        set_layer(1, 1, 1, 0, 4, 4, 8, 8, 32'h80F0A010, 8'h40, 1);
        step(5, 5, 1'b1, "R5");
        set_layer(1, 1, 1, 0, 4, 4, 8, 8, 32'h00F0A010, 8'hFF, 1);
        step(6, 6, 1'b1, "R5");
        set_layer(1, 1, 1, 0, 4, 4, 8, 8, 32'hFFF0A010, 8'hFF, 1);
        step(7, 7, 1'b1, "R6");

        // R7: pipe 1 over background; pipe 0 alone ignores its alpha
        clear_layers();
        bg_val = 24'h00FF00;
        set_layer(1, 1, 1, 2, 0, 0, 4, 4, 32'h55FF0080, 0, 0);
        set_layer(2, 1, 0, 1, 10, 0, 4, 4, 32'h10C0C0C0, 0, 0);
        step(1, 1, 1'b1, "R7");
        step(11, 1, 1'b1, "R7");

        // R9: defect mode at pipe 0, priority 0
        clear_layers();
        bg_val = 24'h0000FF;
        quirk_val = 1'b1;
        set_layer(0, 1, 0, 0, 0, 0, 8, 8, 32'h7F808080, 0, 0);
        step(2, 2, 1'b1, "R9");
        set_layer(0, 1, 0, 0, 0, 0, 8, 8, 32'hFF808080, 0, 0);
        step(2, 2, 1'b1, "R9");
        set_layer(0, 1, 0, 0, 0, 0, 8, 8, 32'hFF808080, 8'hFE, 1);
        step(2, 2, 1'b1, "R9");
        set_layer(0, 1, 0, 1, 0, 0, 8, 8, 32'h7F808080, 0, 0);
        step(2, 2, 1'b1, "R9");
        set_layer(0, 1, 0, 0, 0, 0, 8, 8, 32'h7F808080, 0, 0);
        set_layer(1, 1, 1, 0, 0, 0, 8, 8, 32'h40FF0000, 0, 0);
        step(2, 2, 1'b1, "R9");
        quirk_val = 1'b0;
        step(2, 2, 1'b1, "R9");

        // R2: gaps in the valid strobe hold the output
        step(9, 9, 1'b0, "R2");
        step(1, 1, 1'b0, "R2");
        step(3, 3, 1'b1, "R2");
        step(20, 20, 1'b0, "R2");
        step(20, 20, 1'b1, "R2");
        step(0, 0, 1'b0, "R2");

        // R6: random configurations and pixels
        for (int it = 0; it < 2000; it++) begin
            if (it % 40 == 0) begin
                for (int l = 0; l < NL; l++) begin
                    set_layer(l, int'($urandom_range(1)), int'($urandom_range(1)),
                              int'($urandom_range(3)), int'($urandom_range(70)) - 20,
                              int'($urandom_range(70)) - 20, int'($urandom_range(40)),
                              int'($urandom_range(40)),
                              ($urandom_range(2) == 0) ? {8'hFF, 24'($urandom)} : $urandom,
                              int'($urandom_range(255)), int'($urandom_range(1)));
                end
                bg_val = 24'($urandom);
                quirk_val = ($urandom_range(1) == 1);
            end
            step(int'($urandom_range(63)), int'($urandom_range(63)),
                 ($urandom_range(4) != 0), "R6");
        end

        step(0, 0, 1'b0, "R2");
        step(0, 0, 1'b0, "R2");
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule